// File: doc/BRIEF.md
# Register-Window Bus Router

This block sits between a single CPU bus master and nine peripheral targets. It routes one read or one write at a time. The target is chosen from the low four bits of the CPU address, and the same nibble can mean different things for a read and for a write. Nibble 1110 is an address-add operation when written and a read-and-clear operation when read. The block does no arbitration. It accepts a strobe only while idle and drives a one-hot request to the chosen target. It waits for that target's done pulse, then acknowledges the CPU for one cycle before it returns to idle.

The controller has thirteen operating states plus a reset state. There is one access state per target. Internal registers have separate read and write states. There is one write-end state and one read-end state. Address, write data and direction are captured when a strobe is accepted, and they are held for the targets until the transaction completes. Read data is captured from the selected target in the cycle its done pulse arrives.

Top module: `regwin_router`

## Requirements
- R1: While rst_ni is low, req_o, ack_o and rdata_o are all zero. The first clock edge after reset is released accepts no strobe.
- R2: A write with addr_i[3]=0 requests target 0 (internal registers). For writes with addr_i[3]=1, the request bit follows the nibble: 1000 selects bit 1 (SRAM), 1111 bit 2 (lookup table), 1110 bit 3 (address-add), 1001 bit 4 (SDRAM), 1011 bit 5 (voice generator), 110x bit 6 (MMU) and 1010 bit 7 (SPI). Address bits above bit 3 do not affect decoding.
- R3: A read with addr_i[3]=0 requests bit 0. For other reads, 1000 selects bit 1, 1001 bit 4, 110x bit 6, 1010 bit 7 and 1110 bit 8 (read-and-clear). Reads of 1011 and 1111 select no target.
- R4: req_o is one-hot in the cycle after a strobe is accepted. It stays unchanged until the done_i bit of the selected target is high at a clock edge. Done bits of other targets have no effect.
- R5: ack_o is high for exactly one cycle: the cycle after the selected done is seen. req_o is zero in that cycle, and the block accepts a new strobe in the cycle after the acknowledge.
- R6: A read that selects no target raises ack_o in the cycle after acceptance, with no request and rdata_o equal to zero.
- R7: When wr_i and rd_i are both high in idle, the write is performed.
- R8: rdata_o is cleared when a transaction is accepted. On a read, it loads the selected target's rdata_i slice when that target's done is seen, and it holds that value until the next acceptance. A write acknowledges with rdata_o equal to zero.
- R9: Strobes that arrive while a transaction is in progress are ignored.
- R10: we_o, addr_o and wdata_o take the CPU values at acceptance and hold them until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | CPU write strobe |
| rd_i | input | 1 | CPU read strobe |
| addr_i | input | AW | CPU address, low nibble decoded |
| wdata_i | input | DW | CPU write data |
| ack_o | output | 1 | One-cycle transaction acknowledge |
| rdata_o | output | DW | Read data returned to the CPU |
| req_o | output | 9 | One-hot request per target |
| we_o | output | 1 | Captured transaction direction, 1 = write |
| addr_o | output | AW | Captured address to targets |
| wdata_o | output | DW | Captured write data to targets |
| done_i | input | 9 | Per-target completion pulse |
| rdata_i | input | 9*DW | Per-target read data, target k at bits k*DW upward |

## Verification
The bench builds the router with AW=12 and DW=16. Upper address bits are loaded with changing non-zero patterns, so a decode that wrongly looks above bit 3 shows up. Each target's read slice holds a distinct 16-bit value, so a wrong read-data selection shows up as well. Both strobe directions are swept over all sixteen nibbles with target latencies from zero to three cycles. Stray done pulses on other targets and stray strobes are injected while a transaction is in progress.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int NTGT = 9;

  localparam int T_INT   = 0;
  localparam int T_SRAM  = 1;
  localparam int T_LUT   = 2;
  localparam int T_AADD  = 3;
  localparam int T_SDRAM = 4;
  localparam int T_VOICE = 5;
  localparam int T_MMU   = 6;
  localparam int T_SPI   = 7;
  localparam int T_RCLR  = 8;

  typedef enum logic [3:0] {
    ST_RESET,
    ST_IDLE,
    ST_INT_WR,
    ST_INT_RD,
    ST_SRAM,
    ST_LUT,
    ST_ADDR_ADD,
    ST_SDRAM,
    ST_VOICE,
    ST_MMU,
    ST_SPI,
    ST_RD_CLR,
    ST_WR_END,
    ST_RD_END
  } rw_state_e;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
(
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [3:0] nib_i,
  output rw_state_e  nxt_o
);
  always_comb begin
    nxt_o = ST_IDLE;
    if (wr_i) begin
      if (!nib_i[3]) nxt_o = ST_INT_WR;
      else begin
        case (nib_i[2:0])
          3'b000:         nxt_o = ST_SRAM;
          3'b001:         nxt_o = ST_SDRAM;
          3'b010:         nxt_o = ST_SPI;
          3'b011:         nxt_o = ST_VOICE;
          3'b100, 3'b101: nxt_o = ST_MMU;
          3'b110:         nxt_o = ST_ADDR_ADD;
          3'b111:         nxt_o = ST_LUT;
          default:        nxt_o = ST_WR_END;
        endcase
      end
    end else if (rd_i) begin
      if (!nib_i[3]) nxt_o = ST_INT_RD;
      else begin
        case (nib_i[2:0])
          3'b000:         nxt_o = ST_SRAM;
          3'b001:         nxt_o = ST_SDRAM;
          3'b010:         nxt_o = ST_SPI;
          3'b100, 3'b101: nxt_o = ST_MMU;
          3'b110:         nxt_o = ST_RD_CLR;
          default:        nxt_o = ST_RD_END;
        endcase
      end
    end
  end
endmodule

// File: rtl/regwin_rdmux.sv
module regwin_rdmux
  import regwin_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [NTGT-1:0]    sel_i,
  input  logic [NTGT*DW-1:0] rdata_i,
  output logic [DW-1:0]      rdata_o
);
  logic [DW-1:0] gated [NTGT];

  for (genvar k = 0; k < NTGT; k++) begin : g_gate
    assign gated[k] = rdata_i[k*DW +: DW] & {DW{sel_i[k]}};
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NTGT; k++) rdata_o = rdata_o | gated[k];
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  rw_state_e       dec_nxt_i,
  input  logic [NTGT-1:0] done_i,
  input  logic [DW-1:0]   mux_rdata_i,
  output logic [NTGT-1:0] req_o,
  output logic            ack_o,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic [DW-1:0]   rdata_o
);
  rw_state_e     state_q, state_d;
  logic          accept, hit;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_comb begin
    req_o = '0;
    case (state_q)
      ST_INT_WR, ST_INT_RD: req_o[T_INT]   = 1'b1;
      ST_SRAM:              req_o[T_SRAM]  = 1'b1;
      ST_LUT:               req_o[T_LUT]   = 1'b1;
      ST_ADDR_ADD:          req_o[T_AADD]  = 1'b1;
      ST_SDRAM:             req_o[T_SDRAM] = 1'b1;
      ST_VOICE:             req_o[T_VOICE] = 1'b1;
      ST_MMU:               req_o[T_MMU]   = 1'b1;
      ST_SPI:               req_o[T_SPI]   = 1'b1;
      ST_RD_CLR:            req_o[T_RCLR]  = 1'b1;
      default:              req_o = '0;
    endcase
  end

  assign hit    = |(req_o & done_i);
  assign accept = (state_q == ST_IDLE) && (wr_i || rd_i);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RESET:  state_d = ST_IDLE;
      ST_IDLE:   state_d = dec_nxt_i;
      ST_WR_END,
      ST_RD_END: state_d = ST_IDLE;
      default:   if (hit) state_d = we_q ? ST_WR_END : ST_RD_END;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        we_q    <= wr_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        rdata_q <= '0;
      end else if (hit && !we_q) begin
        rdata_q <= mux_rdata_i;
      end
    end
  end

  assign ack_o   = (state_q == ST_WR_END) || (state_q == ST_RD_END);
  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/regwin_router.sv
module regwin_router
  import regwin_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            ack_o,
  output logic [DW-1:0]   rdata_o,
  output logic [NTGT-1:0] req_o,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  input  logic [NTGT-1:0] done_i,
  input  logic [NTGT*DW-1:0] rdata_i
);
  rw_state_e     dec_nxt;
  logic [DW-1:0] mux_rdata;

  regwin_decode u_decode (
    .wr_i  (wr_i),
    .rd_i  (rd_i),
    .nib_i (addr_i[3:0]),
    .nxt_o (dec_nxt)
  );

  regwin_rdmux #(.DW(DW)) u_rdmux (
    .sel_i   (req_o),
    .rdata_i (rdata_i),
    .rdata_o (mux_rdata)
  );

  regwin_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .dec_nxt_i   (dec_nxt),
    .done_i      (done_i),
    .mux_rdata_i (mux_rdata),
    .req_o       (req_o),
    .ack_o       (ack_o),
    .we_o        (we_o),
    .addr_o      (addr_o),
    .wdata_o     (wdata_o),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/regwin_router_chk.sv
module regwin_router_chk
  import regwin_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ack_o,
  input logic [DW-1:0]   rdata_o,
  input logic [NTGT-1:0] req_o,
  input logic            we_o,
  input logic [AW-1:0]   addr_o,
  input logic [DW-1:0]   wdata_o,
  input logic [NTGT-1:0] done_i
);
  // R4
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o));

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o != '0) && !(|(req_o & done_i)) |=> $stable(req_o));

  // R5
  done_to_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_o & done_i)) |=> ack_o && (req_o == '0));

  // R5
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R8
  wr_ack_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && we_o |-> rdata_o == '0);

  // R10
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o != '0) |=> $stable(addr_o) && $stable(we_o) && $stable(wdata_o));
endmodule

bind regwin_router regwin_router_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ack_o   (ack_o),
  .rdata_o (rdata_o),
  .req_o   (req_o),
  .we_o    (we_o),
  .addr_o  (addr_o),
  .wdata_o (wdata_o),
  .done_i  (done_i)
);

// File: tb/regwin_router_bench.sv
module regwin_router_bench;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NT = 9;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           wr_i = 1'b0, rd_i = 1'b0;
  logic [AW-1:0]  addr_i = '0;
  logic [DW-1:0]  wdata_i = '0;
  logic           ack_o, we_o;
  logic [DW-1:0]  rdata_o, wdata_o;
  logic [NT-1:0]  req_o;
  logic [AW-1:0]  addr_o;
  logic [NT-1:0]  done_i = '0;
  logic [NT*DW-1:0] rdata_i;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  for (genvar k = 0; k < NT; k++) begin : g_resp
    assign rdata_i[k*DW +: DW] = tgt_data(k);
  end

  regwin_router #(.AW(AW), .DW(DW)) u_regwin_router (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o),
    .req_o(req_o), .we_o(we_o), .addr_o(addr_o), .wdata_o(wdata_o),
    .done_i(done_i), .rdata_i(rdata_i)
  );

  function automatic logic [DW-1:0] tgt_data(int k);
    return 16'h5A00 + 16'(k * 16'h0111);
  endfunction

  // reference decode from R2/R3: target index or -1
  function automatic int ref_tgt(bit we, int nib);
    int wmap[8] = '{1, 4, 7, 5, 6, 6, 3, 2};
    int rmap[8] = '{1, 4, 7, -1, 6, 6, 8, -1};
    if (nib < 8) return 0;
    return we ? wmap[nib - 8] : rmap[nib - 8];
  endfunction

  function automatic logic [NT-1:0] oh(int k);
    return (k < 0) ? '0 : NT'(1) << k;
  endfunction

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic xact(bit we, bit both, logic [AW-1:0] a, logic [DW-1:0] d,
                      int dly, bit noise);
    int t;
    logic [DW-1:0] exp_rd;
    t = ref_tgt(we, int'(a[3:0]));
    @(negedge clk);
    wr_i = we; rd_i = !we || both; addr_i = a; wdata_i = d;
    @(posedge clk); @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0;
    // R10 captured fields
    chk(we_o == we, "R10 we", 64'(we_o), 64'(we));
    chk(addr_o == a, "R10 addr", 64'(addr_o), 64'(a));
    chk(wdata_o == d, "R10 wdata", 64'(wdata_o), 64'(d));
    if (t < 0) begin
      // R6 unmapped read
      chk(ack_o && req_o == '0 && rdata_o == '0, "R6 unmapped",
          {ack_o, 7'd0, req_o, rdata_o}, {1'b1, 7'd0, 9'd0, 16'd0});
      @(posedge clk); @(negedge clk);
      chk(!ack_o, "R5 ack one cycle", 64'(ack_o), 0);
      return;
    end
    chk(req_o == oh(t), we ? "R2 write decode" : "R3 read decode",
        64'(req_o), 64'(oh(t)));
    chk(!ack_o && rdata_o == '0, "R8 cleared at accept",
        {ack_o, rdata_o}, 0);
    for (int i = 0; i < dly; i++) begin
      if (noise) begin
        done_i = oh((t + 1 + i) % NT);
        rd_i = 1'b1; addr_i = a ^ 12'h00F;
      end
      @(posedge clk); @(negedge clk);
      chk(req_o == oh(t) && !ack_o, noise ? "R9 R4 busy hold" : "R4 hold",
          {ack_o, req_o}, {1'b0, oh(t)});
    end
    rd_i = 1'b0; addr_i = a;
    done_i = oh(t);
    @(posedge clk); @(negedge clk);
    done_i = '0;
    exp_rd = we ? '0 : tgt_data(t);
    chk(ack_o && req_o == '0, "R5 ack", {ack_o, req_o}, {1'b1, 9'd0});
    chk(rdata_o == exp_rd, "R8 read data", 64'(rdata_o), 64'(exp_rd));
    @(posedge clk); @(negedge clk);
    chk(!ack_o && req_o == '0, "R5 back to idle", {ack_o, req_o}, 0);
    chk(rdata_o == exp_rd, "R8 data held", 64'(rdata_o), 64'(exp_rd));
  endtask

  initial begin
    wr_i = 1'b1; addr_i = 12'h003;
    #1;
    // R1 reset values
    chk(req_o == '0 && !ack_o && rdata_o == '0, "R1 reset",
        {ack_o, req_o, rdata_o}, 0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_i = 1'b0;
    chk(req_o == '0 && !ack_o, "R1 no accept after reset", {ack_o, req_o}, 0);
    @(posedge clk); @(negedge clk);
    chk(req_o == '0, "R1 still idle", 64'(req_o), 0);

    for (int n = 0; n < 16; n++)
      xact(1'b1, 1'b0, AW'((n * 37 + 5) << 4) | AW'(n), DW'(16'hC000 + n), n % 4, n[0]);
    for (int n = 0; n < 16; n++)
      xact(1'b0, 1'b0, AW'((n * 53 + 9) << 4) | AW'(n), DW'(16'h3000 + n), (n + 1) % 4, !n[0]);

    // R7 both strobes on 1110: address-add write wins
    xact(1'b1, 1'b1, 12'hA5E, 16'h7777, 1, 1'b0);
    // R8 read then write then read
    xact(1'b0, 1'b0, 12'h2E8, 16'h0, 0, 1'b0);
    xact(1'b1, 1'b0, 12'h2E8, 16'h1234, 2, 1'b1);
    xact(1'b0, 1'b0, 12'hFFE, 16'h0, 3, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule